// File: doc/BRIEF.md
# ADPCM All-Zero Word Detector

This block watches the serial ADPCM input of one channel and reports when a received code word consists only of zero bits. Each 8 kHz frame carries one word of `WORD_BITS` bits (four by default), sent most significant bit first. The bits are sampled on rising edges of the ADPCM bit clock, and a frame-sync strobe marks the first bit of each word.

Once the last bit of a word has been sampled, the block compares the whole word against the all-zero pattern. The result goes into a single registered flag. That flag keeps its value until the same point in the next frame. When a through mode is selected, the data on the line is not ADPCM, so detection is suppressed and the flag is held low. The block does not decode the ADPCM word itself.

Top module: `adpcm_zero_detect`

## Requirements
- R1: While reset is low, the flag is 0. After reset the block stays idle until the first frame sync, so bits clocked in before that sync never set the flag.
- R2: A word of four 0 bits sets the flag to 1. The flag takes this value on the rising clock edge that samples the fourth bit of the word. The first bit of a word is the one sampled on an edge where frame sync is high.
- R3: A word with any bit at 1 clears the flag to 0 on the rising edge that samples its fourth bit. This holds whichever bit position carries the 1.
- R4: Outside the edge that samples a fourth bit, the flag does not change. This includes the first three bits of the following word.
- R5: When two all-zero words arrive back to back, the flag stays at 1 on every edge between them, with no drop.
- R6: After the fourth bit, any further clocks in the same frame are ignored, whatever their data, until the next frame sync.
- R7: A frame sync always restarts the word. Bits received before it in an unfinished word take no part in the next decision.
- R8: While through mode is high, the flag is forced to 0 on the next rising edge and no word can set it. Detection resumes with the first word that completes after through mode drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | ADPCM bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | High during the first (MSB) bit of a word |
| sdata | input | 1 | Serial ADPCM input data |
| thru_en | input | 1 | Through-mode select; 1 disables detection |
| zero_flag | output | 1 | Registered all-zero word indication |

## Verification
A wrong bit count shows at the port as a flag that updates on the wrong edge. The update comes one bit early or late, or it fires again on the trailing clocks of a frame, so a count fault appears within the first frame.

A running OR that is not cleared at frame sync carries a 1 into the next word. That turns a 0000 word that follows a non-zero word into a 0 flag, and it shows on the very next word.

All sixteen words are run after each of the sixteen possible preceding words, and the flag is checked on every edge. A hold or update fault therefore appears within one frame of the word that triggers it.

// File: rtl/adpcm_zero_detect.sv
module adpcm_zero_detect #(
  parameter int WORD_BITS = 4
) (
  input  logic bclk,
  input  logic rst_n,
  input  logic frame_sync,
  input  logic sdata,
  input  logic thru_en,
  output logic zero_flag
);
  localparam int CW = $clog2(WORD_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);
  localparam logic [CW-1:0] DONE = CW'(WORD_BITS);

  logic [CW-1:0] bit_cnt;
  logic          ones_seen;

  wire word_or = ones_seen | sdata;
  wire at_last = !frame_sync && (bit_cnt == LAST);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= DONE;
      ones_seen <= 1'b0;
    end else if (frame_sync) begin
      bit_cnt   <= CW'(1);
      ones_seen <= sdata;
    end else if (bit_cnt != DONE) begin
      bit_cnt   <= bit_cnt + CW'(1);
      ones_seen <= word_or;
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)       zero_flag <= 1'b0;
    else if (thru_en) zero_flag <= 1'b0;
    else if (at_last) zero_flag <= ~word_or;
  end

  // R4
  flag_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (!thru_en && !at_last) |=> $stable(zero_flag));

  // R8
  thru_clear_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    thru_en |=> !zero_flag);

  // R2
  rise_at_last_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(zero_flag) |-> ($past(bit_cnt) == LAST && !$past(thru_en) && !$past(frame_sync)));

  // R3
  fall_cause_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    $fell(zero_flag) |-> ($past(thru_en) || $past(bit_cnt) == LAST));

  // R6
  cnt_bound_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    bit_cnt <= DONE);

  // R7
  sync_restart_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_sync |=> (bit_cnt == CW'(1)));
endmodule

// File: tb/adpcm_zero_detect_tb.sv
`timescale 1ns/1ps
module adpcm_zero_detect_tb;
  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0;
  logic sdata = 1'b0;
  logic thru_en = 1'b0;
  logic zero_flag;
  int   errors = 0;
  int   checks = 0;

  adpcm_zero_detect #(.WORD_BITS(4)) u_dut (
    .bclk(bclk), .rst_n(rst_n), .frame_sync(frame_sync),
    .sdata(sdata), .thru_en(thru_en), .zero_flag(zero_flag)
  );

  always #2.5 bclk = ~bclk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: zero_flag=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clk_bit(input logic sync, input logic d);
    @(negedge bclk);
    frame_sync = sync;
    sdata      = d;
    @(posedge bclk);
    #1;
  endtask

  // sends a 4-bit word MSB first; checks hold on bits 1..3 and result on bit 4
  task automatic send_word(input logic [3:0] w, input logic held, input logic exp, input string req);
    for (int i = 0; i < 4; i++) begin
      clk_bit(i == 0, w[3-i]);
      if (i < 3) chk("R4", zero_flag, held);
      else       chk(req, zero_flag, exp);
    end
  endtask

  initial begin
    #1;
    chk("R1", zero_flag, 1'b0);
    @(negedge bclk); rst_n = 1'b1;
    // R1: zeros before the first sync must not set the flag
    for (int i = 0; i < 6; i++) begin
      clk_bit(1'b0, 1'b0);
      chk("R1", zero_flag, 1'b0);
    end

    // R2 R3 R5 R4 R6: every word after every preceding word
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 16; c++) begin
        send_word(4'(p), zero_flag, (p == 0), (p == 0) ? "R2" : "R3");
        for (int k = 0; k < 2; k++) begin
          clk_bit(1'b0, 1'b1);
          chk("R6", zero_flag, (p == 0));
        end
        send_word(4'(c), (p == 0), (c == 0),
                  (c == 0) ? ((p == 0) ? "R5" : "R2") : "R3");
        for (int k = 0; k < 3; k++) begin
          clk_bit(1'b0, k[0]);
          chk("R6", zero_flag, (c == 0));
        end
      end
    end

    // R7: partial word holding a 1, restarted by sync, then 0000
    send_word(4'b0101, 1'b0, 1'b0, "R3");
    clk_bit(1'b1, 1'b1);
    clk_bit(1'b0, 1'b1);
    chk("R7", zero_flag, 1'b0);
    send_word(4'b0000, 1'b0, 1'b1, "R7");
    // R7: partial zeros, restart with 1000 -> must clear
    clk_bit(1'b1, 1'b0);
    clk_bit(1'b0, 1'b0);
    chk("R7", zero_flag, 1'b1);
    send_word(4'b1000, 1'b1, 1'b0, "R7");

    // R8: through mode clears and blocks detection
    send_word(4'b0000, 1'b0, 1'b1, "R2");
    @(negedge bclk); thru_en = 1'b1;
    @(posedge bclk); #1;
    chk("R8", zero_flag, 1'b0);
    send_word(4'b0000, 1'b0, 1'b0, "R8");
    send_word(4'b0000, 1'b0, 1'b0, "R8");
    @(negedge bclk); thru_en = 1'b0;
    send_word(4'b0000, 1'b0, 1'b1, "R8");

    // R1: reset mid-run clears the flag
    @(negedge bclk); rst_n = 1'b0;
    #1;
    chk("R1", zero_flag, 1'b0);
    @(negedge bclk); rst_n = 1'b1;
    clk_bit(1'b0, 1'b0);
    clk_bit(1'b0, 1'b0);
    clk_bit(1'b0, 1'b0);
    clk_bit(1'b0, 1'b0);
    chk("R1", zero_flag, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge bclk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule